// File: doc/BRIEF.md
# Timed-Token Ring Station Controller

This block decides, for one station on a timed-token ring, how long the station may keep the token on each visit. A one-cycle grant pulse hands the token to the station. The station then always gets a synchronous transmit window of a fixed number of time units. After that, it gets an asynchronous window only if the token came back around the ring quickly enough. It returns the token with a one-cycle release pulse. Time is counted in units marked by a tick-enable input, not in clock cycles.

The controller keeps two saturating timers and swaps their roles on every visit. The first timer is cleared when the token arrives and times the current hold. The second was cleared on the previous arrival, so it holds the time the token took to go round the ring. The rotation timer is compared against the target rotation time in two places: once to decide whether an asynchronous window is granted, and again to bound that window. The station reports its phase (idle, sync, async) and which timer is currently timing the visit. A grant that arrives while the station already holds the token is counted as a protocol fault.

Top module: `ttr_station`

## Requirements
- R1: During reset and after it, the station is idle and `visit_sel` is 0. `token_release` and `protocol_error` are low. Both timers read as expired (TRTT+1), so the first visit gets no asynchronous window.
- R2: Each timer moves up by one only in a cycle where `tick` is high, and it saturates at TRTT+1. With `tick` held low, the station stays in sync indefinitely. After a long idle stretch, no asynchronous window is granted.
- R3: A `token_grant` in an idle cycle puts the station in sync on the next cycle and clears the visit timer to 0. The other timer is left running.
- R4: Sync is left on the cycle after the visit timer equals SA, so a visit spends between SA and SA+1 ticks in sync.
- R5: When sync ends, the station goes to async if the rotation timer is at most TRTT−1. Otherwise it releases the token directly.
- R6: In async, the token is released after the first cycle in which `async_pending` is low or the rotation timer has reached TRTT. With `async_pending` low on entry, async lasts exactly one cycle.
- R7: `token_release` is high for exactly one cycle. That is the first cycle in the opposite idle state, and in it the timer that measured the rotation reads TRTT+1.
- R8: `visit_sel` toggles on every release, so the roles of the two timers alternate from one visit to the next.
- R9: A `token_grant` outside an idle state has no effect on the phase. It sets `protocol_error` on the next cycle, and `protocol_error` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One time unit elapses in this cycle |
| token_grant | input | 1 | One-cycle pulse: token handed to this station |
| async_pending | input | 1 | Asynchronous traffic is waiting |
| token_release | output | 1 | One-cycle pulse: token passed on |
| in_idle | output | 1 | Station is not holding the token |
| in_sync | output | 1 | Synchronous window active |
| in_async | output | 1 | Asynchronous window active |
| visit_sel | output | 1 | Index of the timer that times the current or next visit |
| protocol_error | output | 1 | Sticky: a grant arrived while holding the token |

## Verification
The assertions assume that a grant is a single-cycle pulse and that it arrives at an idle station, except in the one deliberate fault case. They also assume that `tick` eventually recurs, because without it the bounds on the sync and async windows are never reached. The bench models a four-station ring. After each release it waits a number of ticks that stands for the other three stations' holds, then grants the token again. It raises a second grant only once, while the station is parked in sync with ticks stopped, so that `protocol_error` can be checked without disturbing the other checks.

// File: rtl/ttr_pkg.sv
package ttr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SYNC  = 2'd1,
    PH_ASYNC = 2'd2
  } phase_e;
endpackage

// File: rtl/ttr_rst_sync.sv
module ttr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/ttr_timer.sv
// Saturating time-unit counter with clear and reload-to-expired controls.
module ttr_timer #(
  parameter int unsigned TW      = 4,
  parameter int unsigned EXPIRED = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic          load,
  output logic [TW-1:0] cnt_q
);
  localparam logic [TW-1:0] EXP_W = EXPIRED[TW-1:0];

  logic [TW-1:0] cnt_d;
  logic          upd;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = EXP_W;
    end else if (tick && (cnt_q != EXP_W)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign upd = clr | load | tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= EXP_W;
    end else if (upd) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ttr_ctrl.sv
// Six-state visit sequencer: phase (idle/sync/async) times timer-role select.
module ttr_ctrl
  import ttr_pkg::*;
#(
  parameter int unsigned SA   = 1,
  parameter int unsigned TRTT = 9,
  parameter int unsigned TW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          token_grant,
  input  logic          async_pending,
  input  logic [TW-1:0] visit_cnt,
  input  logic [TW-1:0] rot_cnt,
  output phase_e        phase_q,
  output logic          sel_q,
  output logic          release_q,
  output logic          error_q,
  output logic          clr_visit,
  output logic          load_rot
);
  localparam logic [TW-1:0] SA_W   = SA[TW-1:0];
  localparam logic [TW-1:0] TRTT_W = TRTT[TW-1:0];

  phase_e phase_d;
  logic   sel_d;
  logic   release_d;
  logic   error_d;
  logic   give_up;

  always_comb begin
    phase_d   = phase_q;
    sel_d     = sel_q;
    release_d = 1'b0;
    clr_visit = 1'b0;
    load_rot  = 1'b0;
    give_up   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (token_grant) begin
          phase_d   = PH_SYNC;
          clr_visit = 1'b1;
        end
      end
      PH_SYNC: begin
        if (visit_cnt >= SA_W) begin
          if (rot_cnt < TRTT_W) begin
            phase_d = PH_ASYNC;
          end else begin
            give_up = 1'b1;
          end
        end
      end
      PH_ASYNC: begin
        if (!async_pending || (rot_cnt >= TRTT_W)) begin
          give_up = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (give_up) begin
      phase_d   = PH_IDLE;
      sel_d     = ~sel_q;
      release_d = 1'b1;
      load_rot  = 1'b1;
    end
    error_d = error_q | (token_grant && (phase_q != PH_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      sel_q     <= 1'b0;
      release_q <= 1'b0;
      error_q   <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      sel_q     <= sel_d;
      release_q <= release_d;
      error_q   <= error_d;
    end
  end
endmodule

// File: rtl/ttr_station.sv
module ttr_station
  import ttr_pkg::*;
#(
  parameter int unsigned SA   = 1,
  parameter int unsigned TRTT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic token_grant,
  input  logic async_pending,
  output logic token_release,
  output logic in_idle,
  output logic in_sync,
  output logic in_async,
  output logic visit_sel,
  output logic protocol_error
);
  localparam int unsigned EXPIRED = TRTT + 1;
  localparam int unsigned TW      = $clog2(EXPIRED + 1);
  localparam int unsigned NTMR    = 2;

  logic          rst_i_n;
  logic [TW-1:0] cnt [NTMR];
  logic [TW-1:0] visit_cnt;
  logic [TW-1:0] rot_cnt;
  logic          clr_visit;
  logic          load_rot;
  phase_e        phase;

  ttr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    localparam logic IDX = 1'(i);
    logic clr_i;
    logic load_i;
    assign clr_i  = clr_visit && (visit_sel == IDX);
    assign load_i = load_rot  && (visit_sel != IDX);
    ttr_timer #(
      .TW      (TW),
      .EXPIRED (EXPIRED)
    ) u_tmr (
      .clk   (clk),
      .rst_n (rst_i_n),
      .tick  (tick),
      .clr   (clr_i),
      .load  (load_i),
      .cnt_q (cnt[i])
    );
  end

  assign visit_cnt = cnt[visit_sel];
  assign rot_cnt   = cnt[~visit_sel];

  ttr_ctrl #(
    .SA   (SA),
    .TRTT (TRTT),
    .TW   (TW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .token_grant   (token_grant),
    .async_pending (async_pending),
    .visit_cnt     (visit_cnt),
    .rot_cnt       (rot_cnt),
    .phase_q       (phase),
    .sel_q         (visit_sel),
    .release_q     (token_release),
    .error_q       (protocol_error),
    .clr_visit     (clr_visit),
    .load_rot      (load_rot)
  );

  assign in_idle  = (phase == PH_IDLE);
  assign in_sync  = (phase == PH_SYNC);
  assign in_async = (phase == PH_ASYNC);
endmodule

// File: rtl/ttr_station_chk.sv
module ttr_station_chk #(
  parameter int unsigned SA   = 1,
  parameter int unsigned TRTT = 9,
  parameter int unsigned TW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          token_grant,
  input logic          token_release,
  input logic          in_idle,
  input logic          in_sync,
  input logic          in_async,
  input logic          visit_sel,
  input logic          protocol_error,
  input logic [TW-1:0] visit_cnt,
  input logic [TW-1:0] rot_cnt
);
  // R2
  timer_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_cnt <= TW'(TRTT + 1)) && (rot_cnt <= TW'(TRTT + 1)));

  // R3
  grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && token_grant) |=> (in_sync && (visit_cnt == '0)));

  // R4
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> (visit_cnt <= TW'(SA)));

  // R6
  async_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_async |-> (rot_cnt <= TW'(TRTT)));

  // R7
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_release |=> !token_release);

  // R7
  release_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_release |-> (in_idle && (visit_cnt == TW'(TRTT + 1))));

  // R8
  sel_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_release |-> (visit_sel != $past(visit_sel)));

  // R9
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    protocol_error |=> protocol_error);

  // R9
  error_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (token_grant && !in_idle) |=> (protocol_error && $stable(visit_sel)));

  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({in_idle, in_sync, in_async}));
endmodule

bind ttr_station ttr_station_chk #(
  .SA   (SA),
  .TRTT (TRTT),
  .TW   (TW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .token_grant    (token_grant),
  .token_release  (token_release),
  .in_idle        (in_idle),
  .in_sync        (in_sync),
  .in_async       (in_async),
  .visit_sel      (visit_sel),
  .protocol_error (protocol_error),
  .visit_cnt      (visit_cnt),
  .rot_cnt        (rot_cnt)
);

// File: tb/ttr_station_tb.sv
`timescale 1ns/1ps
module ttr_station_tb;
  localparam int SA   = 1;
  localparam int TRTT = 9;
  localparam int EXP  = TRTT + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic token_grant;
  logic async_pending;
  logic token_release, in_idle, in_sync, in_async, visit_sel, protocol_error;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  cmp_en = 1'b0;
  bit  tick_en = 1'b0;

  always #10 clk = ~clk;

  ttr_station #(.SA(SA), .TRTT(TRTT)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .token_grant    (token_grant),
    .async_pending  (async_pending),
    .token_release  (token_release),
    .in_idle        (in_idle),
    .in_sync        (in_sync),
    .in_async       (in_async),
    .visit_sel      (visit_sel),
    .protocol_error (protocol_error)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 idle, 1 sync, 2 async; two timers by index.
  int m_ph, m_sel;
  int m_t[2];
  bit m_rel, m_err;

  always @(posedge clk or negedge rst_n) begin
    int nt0, nt1, nph, nsel, vis, rot;
    bit leave;
    if (!rst_n) begin
      m_ph = 0; m_sel = 0; m_t[0] = EXP; m_t[1] = EXP; m_rel = 0; m_err = 0;
    end else begin
      nt0 = (tick && m_t[0] < EXP) ? m_t[0] + 1 : m_t[0];
      nt1 = (tick && m_t[1] < EXP) ? m_t[1] + 1 : m_t[1];
      vis = m_t[m_sel];
      rot = m_t[1 - m_sel];
      nph = m_ph; nsel = m_sel; leave = 0;
      if (token_grant && m_ph != 0) m_err = 1;
      if (m_ph == 0) begin
        if (token_grant) begin
          nph = 1;
          if (m_sel == 0) nt0 = 0; else nt1 = 0;
        end
      end else if (m_ph == 1) begin
        if (vis >= SA) begin
          if (rot <= TRTT - 1) nph = 2; else leave = 1;
        end
      end else begin
        if (!async_pending || rot >= TRTT) leave = 1;
      end
      if (leave) begin
        if (m_sel == 0) nt1 = EXP; else nt0 = EXP;
        nph = 0; nsel = 1 - m_sel;
      end
      m_rel = leave;
      m_ph = nph; m_sel = nsel; m_t[0] = nt0; m_t[1] = nt1;
    end
  end

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    int dph;
    if (cmp_en) begin
      dph = in_sync ? 1 : (in_async ? 2 : (in_idle ? 0 : 3));
      chk(m_ph == 0 ? "R3" : (m_ph == 1 ? "R4" : "R6"), "phase", dph, m_ph);
      chk("R7", "token_release", token_release, m_rel);
      chk("R8", "visit_sel", visit_sel, m_sel);
      chk("R9", "protocol_error", protocol_error, m_err);
    end
  end

  // Time-unit source: one tick every third cycle while enabled.
  initial begin
    int div;
    div = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      if (tick_en) begin
        div++;
        if (div >= 3) begin tick = 1'b1; div = 0; end
        else tick = 1'b0;
      end else begin
        tick = 1'b0;
      end
    end
  end

  task automatic pulse_grant();
    @(negedge clk); token_grant = 1'b1;
    @(negedge clk); token_grant = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int c;
    c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick) c++;
    end
  endtask

  // Other three stations hold for 'gap' ticks, then this station gets the token.
  task automatic run_visit(input int gap, input bit ap, output bit saw_async,
                           output int async_cycles, output int sync_ticks,
                           output bit sel_before, output bit sel_after);
    async_pending = ap;
    wait_ticks(gap);
    @(negedge clk); #1;
    sel_before = visit_sel;
    pulse_grant();
    #1;
    saw_async = 0; async_cycles = 0; sync_ticks = 0;
    while (!token_release) begin
      if (in_async) begin saw_async = 1; async_cycles++; end
      if (in_sync && tick) sync_ticks++;
      @(negedge clk); #1;
    end
    sel_after = visit_sel;
    @(negedge clk); #1;
    chk("R7", "release width", token_release, 0);
  endtask

  initial begin
    bit sa_, sb, sc;
    int ac, st;
    rst_n = 1'b0; token_grant = 1'b0; async_pending = 1'b0;
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    #1;
    chk("R1", "idle in reset", in_idle, 1);
    chk("R1", "sel in reset", visit_sel, 0);
    chk("R1", "release in reset", token_release, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk("R1", "idle after reset", in_idle, 1);
    chk("R1", "error after reset", protocol_error, 0);
    tick_en = 1'b1;

    // First visit: rotation timer starts expired.
    run_visit(1, 1'b1, sa_, ac, st, sb, sc);
    chk("R1", "no async on first visit", sa_, 0);
    chk("R5", "direct release when rotation expired", sa_, 0);
    chk("R4", "sync ticks within [SA,SA+1]", (st >= SA && st <= SA + 1), 1);
    chk("R8", "role swap", sc, !sb);

    // Fast rotation, nothing pending: one-cycle async.
    run_visit(2, 1'b0, sa_, ac, st, sb, sc);
    chk("R5", "async granted on fast rotation", sa_, 1);
    chk("R6", "early release length", ac, 1);
    chk("R8", "role swap", sc, !sb);

    // Fast rotation with traffic pending: async held until rotation reaches TRTT.
    run_visit(1, 1'b1, sa_, ac, st, sb, sc);
    chk("R5", "async granted with traffic", sa_, 1);
    chk("R6", "async lasts past one cycle", (ac > 1), 1);
    chk("R8", "role swap", sc, !sb);

    // Long idle: timers saturate, no async.
    run_visit(40, 1'b1, sa_, ac, st, sb, sc);
    chk("R2", "no async after saturation", sa_, 0);

    // No ticks: sync never ends.
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    pulse_grant();
    for (int k = 0; k < 20; k++) begin
      #1;
      chk("R2", "sync held without ticks", in_sync, 1);
      @(negedge clk);
    end
    tick_en = 1'b1;
    while (!in_idle) @(negedge clk);

    // Ring traffic with varying rotation and pending traffic.
    for (int v = 0; v < 40; v++) begin
      run_visit($urandom_range(0, 12), 1'($urandom_range(0, 1)), sa_, ac, st, sb, sc);
      chk("R4", "sync ticks within [SA,SA+1]", (st >= SA && st <= SA + 1), 1);
      chk("R8", "role swap", sc, !sb);
    end

    // Second grant while holding the token.
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    pulse_grant();
    pulse_grant();
    #1;
    chk("R9", "error raised", protocol_error, 1);
    chk("R9", "phase unchanged by stray grant", in_sync, 1);
    tick_en = 1'b1;
    while (!in_idle) @(negedge clk);
    repeat (10) @(negedge clk);
    #1;
    chk("R9", "error sticky", protocol_error, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule